// File: doc/BRIEF.md
# Key-Protected Flash Command Controller

This block sits between a register bus and a flash array's command port. Software first loads a flash offset into an address register and a program word into a data register. It then writes a control register. The upper half of that write must carry an unlock key, and exactly one of its four command bits must be set: word program, page erase, mass erase or commit. Once a command is accepted, the controller presents it on a valid/ready command port. It then holds the command bit set for a duration, given in clock cycles, that depends on the operation. The bit clears by itself when that time has elapsed, so polling the control register shows whether the operation is still busy.

A completion sets a raw interrupt flag. The interrupt output is that flag gated by a mask bit. Writing a 1 to the clear register drops the flag. While an operation is pending or running, the controller ignores writes to the address, data and control registers, so the operands stay fixed. The command port follows a valid/ready rule: once `cmd_valid` rises, it stays high, with operation, address and data unchanged, until the cycle in which `cmd_ready` is also high. The flash side may stall for as long as it needs. The controller starts the duration count only after that handshake.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, every register reads zero (address, data, control, mask, raw flag and masked flag), `cmd_valid` is low and `irq` is low.
- R2: Register select 0 is the address register. It keeps write bits 17:0, and bits 31:18 read zero. Select 1 is the 32-bit data register. Both read back the last value written while idle.
- R3: A write to select 2 whose bits 31:16 equal 0xA442 and whose bits 3:0 have exactly one bit set is accepted. The command bits are bit 0 word program, bit 1 page erase, bit 2 mass erase and bit 3 commit. The set bit reads back in select 2 from the next cycle, and bits 31:4 read zero.
- R4: A control write with any other key value, with no command bit set, or with more than one command bit set changes nothing: the control register stays zero and `cmd_valid` stays low.
- R5: From the cycle after an accepted write, `cmd_valid` is high with `cmd_op` equal to the set bit's index (0 program, 1 page erase, 2 mass erase, 3 commit). `cmd_valid`, `cmd_op`, `cmd_addr` and `cmd_data` hold steady until a cycle in which `cmd_ready` is high.
- R6: `cmd_addr` is the address register with bits 1:0 forced to zero for a program and bits 9:0 forced to zero for a page erase. For mass erase and commit it is passed unchanged. `cmd_data` is the data register for a program and zero for every other operation.
- R7: After the handshake, the command bit reads 1 for exactly the operation's duration parameter in cycles, then reads 0.
- R8: While a command bit is set, writes to the address, data and control registers are ignored.
- R9: A completion sets the raw flag (select 4, bit 0). `irq` and select 5 bit 0 equal the raw flag ANDed with mask bit 0 (select 3). Writing a value with bit 0 set to select 5 clears the raw flag, but a completion in the same cycle wins and leaves it set. Unused selects read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for writes |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 3 | Register select for reads |
| reg_rdata | output | 32 | Read data (combinational) |
| cmd_valid | output | 1 | Command offered to the flash array |
| cmd_ready | input | 1 | Flash array accepts the command |
| cmd_op | output | 2 | Operation code |
| cmd_addr | output | 18 | Aligned flash offset |
| cmd_data | output | 32 | Program word |
| irq | output | 1 | Masked completion interrupt |

## Verification
Completion of an operation and a software clear of the raw interrupt flag can land on the same clock edge. The bench provokes this by issuing the clear write so that its edge is exactly the last cycle of the operation's count, which it derives from the observed handshake and the duration parameter. It judges the outcome by reading the raw flag afterwards: it must still be set, and a second clear must then drop it. Random ready stalls also let a stalled command port overlap with blocked operand writes, and the bench checks that the offered command does not change.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int unsigned REG_W = 32;
  localparam logic [15:0] UNLOCK_KEY = 16'hA442;

  localparam logic [2:0] SEL_ADDR  = 3'd0;
  localparam logic [2:0] SEL_DATA  = 3'd1;
  localparam logic [2:0] SEL_CTRL  = 3'd2;
  localparam logic [2:0] SEL_MASK  = 3'd3;
  localparam logic [2:0] SEL_RAW   = 3'd4;
  localparam logic [2:0] SEL_CLEAR = 3'd5;

  typedef enum logic [1:0] {
    OP_WORD   = 2'd0,
    OP_PAGE   = 2'd1,
    OP_MASS   = 2'd2,
    OP_COMMIT = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2
  } st_e;
endpackage

// File: rtl/flash_cmd_operands.sv
module flash_cmd_operands
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             lock,
  output logic [AW-1:0]    addr_q,
  output logic [REG_W-1:0] data_q
);
  logic open_wr;
  assign open_wr = wr && !lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (open_wr) begin
      if (sel == SEL_ADDR) addr_q <= wdata[AW-1:0];
      if (sel == SEL_DATA) data_q <= wdata;
    end
  end
endmodule

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
#(
  parameter int unsigned NCMD = 4
) (
  input  logic            wr,
  input  logic [2:0]      sel,
  input  logic [15:0]     key,
  input  logic [NCMD-1:0] bits,
  input  logic            busy,
  output logic            accept,
  output op_e             op
);
  logic key_ok;
  logic single;
  logic [1:0] idx;

  assign key_ok = (key == UNLOCK_KEY);
  assign single = $onehot(bits);

  always_comb begin
    idx = '0;
    for (int i = 0; i < NCMD; i++) begin
      if (bits[i]) idx = 2'(i);
    end
  end

  assign op     = op_e'(idx);
  assign accept = wr && (sel == SEL_CTRL) && key_ok && single && !busy;
endmodule

// File: rtl/flash_cmd_timer.sv
module flash_cmd_timer
  import flash_cmd_pkg::*;
#(
  parameter int unsigned T_WORD   = 16,
  parameter int unsigned T_PAGE   = 160,
  parameter int unsigned T_MASS   = 1600,
  parameter int unsigned T_COMMIT = 16,
  parameter int unsigned CW       = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  op_e  op,
  output logic zero
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;

  always_comb begin
    unique case (op)
      OP_WORD:   reload = CW'(T_WORD - 1);
      OP_PAGE:   reload = CW'(T_PAGE - 1);
      OP_MASS:   reload = CW'(T_MASS - 1);
      default:   reload = CW'(T_COMMIT - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= reload;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/flash_cmd_irq.sv
module flash_cmd_irq
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [2:0] sel,
  input  logic       wbit,
  input  logic       done,
  output logic       raw,
  output logic       mask,
  output logic       masked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw  <= 1'b0;
      mask <= 1'b0;
    end else begin
      if (wr && sel == SEL_MASK) mask <= wbit;
      if (done)                                raw <= 1'b1;
      else if (wr && sel == SEL_CLEAR && wbit) raw <= 1'b0;
    end
  end

  assign masked = raw & mask;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW         = 18,
  parameter int unsigned WORD_ALIGN = 2,
  parameter int unsigned PAGE_ALIGN = 10,
  parameter int unsigned T_WORD     = 16,
  parameter int unsigned T_PAGE     = 160,
  parameter int unsigned T_MASS     = 1600,
  parameter int unsigned T_COMMIT   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  input  logic [2:0]  reg_rsel,
  output logic [31:0] reg_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [1:0]  cmd_op,
  output logic [AW-1:0] cmd_addr,
  output logic [31:0] cmd_data,
  output logic        irq
);
  localparam int unsigned NCMD  = 4;
  localparam int unsigned T_A   = (T_WORD > T_COMMIT) ? T_WORD : T_COMMIT;
  localparam int unsigned T_B   = (T_PAGE > T_MASS) ? T_PAGE : T_MASS;
  localparam int unsigned T_MAX = (T_A > T_B) ? T_A : T_B;
  localparam int unsigned CW    = $clog2(T_MAX + 1);
  localparam logic [AW-1:0] WORD_MASK = {AW{1'b1}} << WORD_ALIGN;
  localparam logic [AW-1:0] PAGE_MASK = {AW{1'b1}} << PAGE_ALIGN;

  st_e             state;
  op_e             op_q;
  op_e             new_op;
  logic [NCMD-1:0] cmd_bits;
  logic            busy;
  logic            accept;
  logic            tmr_load;
  logic            tmr_zero;
  logic            done;
  logic [AW-1:0]   addr_q;
  logic [31:0]     data_q;
  logic            raw_flag;
  logic            irq_mask;
  logic            masked_flag;

  assign busy = (state != ST_IDLE);

  flash_cmd_operands #(.AW(AW)) i_operands (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .sel    (reg_sel),
    .wdata  (reg_wdata),
    .lock   (busy),
    .addr_q (addr_q),
    .data_q (data_q)
  );

  flash_cmd_decode #(.NCMD(NCMD)) i_decode (
    .wr     (reg_wr),
    .sel    (reg_sel),
    .key    (reg_wdata[31:16]),
    .bits   (reg_wdata[NCMD-1:0]),
    .busy   (busy),
    .accept (accept),
    .op     (new_op)
  );

  flash_cmd_timer #(
    .T_WORD(T_WORD), .T_PAGE(T_PAGE), .T_MASS(T_MASS),
    .T_COMMIT(T_COMMIT), .CW(CW)
  ) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .op    (op_q),
    .zero  (tmr_zero)
  );

  flash_cmd_irq i_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .sel    (reg_sel),
    .wbit   (reg_wdata[0]),
    .done   (done),
    .raw    (raw_flag),
    .mask   (irq_mask),
    .masked (masked_flag)
  );

  assign tmr_load = (state == ST_PEND) && cmd_ready;
  assign done     = (state == ST_RUN) && tmr_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      op_q     <= OP_WORD;
      cmd_bits <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_PEND;
          op_q     <= new_op;
          cmd_bits <= reg_wdata[NCMD-1:0];
        end
        ST_PEND: if (cmd_ready) state <= ST_RUN;
        ST_RUN: if (tmr_zero) begin
          state    <= ST_IDLE;
          cmd_bits <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd_valid = (state == ST_PEND);
  assign cmd_op    = op_q;

  always_comb begin
    unique case (op_q)
      OP_WORD: cmd_addr = addr_q & WORD_MASK;
      OP_PAGE: cmd_addr = addr_q & PAGE_MASK;
      default: cmd_addr = addr_q;
    endcase
  end

  assign cmd_data = (op_q == OP_WORD) ? data_q : '0;
  assign irq      = masked_flag;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_rsel)
      SEL_ADDR:  reg_rdata = 32'(addr_q);
      SEL_DATA:  reg_rdata = data_q;
      SEL_CTRL:  reg_rdata = 32'(cmd_bits);
      SEL_MASK:  reg_rdata = 32'(irq_mask);
      SEL_RAW:   reg_rdata = 32'(raw_flag);
      SEL_CLEAR: reg_rdata = 32'(masked_flag);
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk #(
  parameter int unsigned AW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [AW-1:0] cmd_addr,
  input logic [31:0]   cmd_data,
  input logic          irq,
  input logic [3:0]    cmd_bits,
  input logic          irq_mask,
  input logic          busy
);
  a_r5_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_data));

  a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd0 |-> cmd_addr[1:0] == 2'b00);

  a_r6_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 2'd1 |-> cmd_addr[9:0] == 10'd0 && cmd_data == 32'd0);

  a_r4_single_command: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_bits));

  a_r7_valid_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_bits != 4'd0);

  a_r8_operands_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || ($stable(cmd_addr) && $stable(cmd_data) && $stable(cmd_bits)));

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_mask);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk #(.AW(AW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_addr  (cmd_addr),
  .cmd_data  (cmd_data),
  .irq       (irq),
  .cmd_bits  (cmd_bits),
  .irq_mask  (irq_mask),
  .busy      (busy)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int T_WORD = 16, T_PAGE = 160, T_MASS = 1600, T_COMMIT = 16;
  localparam logic [15:0] KEY = 16'hA442;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_sel = '0, reg_rsel = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cmd_valid, cmd_ready = 1'b1;
  logic [1:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [31:0] cmd_data;
  logic irq;
  int checks = 0, errors = 0;
  int ready_mode = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.AW(AW), .T_WORD(T_WORD), .T_PAGE(T_PAGE),
                   .T_MASS(T_MASS), .T_COMMIT(T_COMMIT)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .irq(irq));

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (ready_mode == 0)      cmd_ready = 1'b0;
    else if (ready_mode == 1) cmd_ready = 1'b1;
    else                      cmd_ready = 1'($urandom_range(0, 1));
  end

  function automatic int dur(input int op);
    case (op)
      0: return T_WORD;
      1: return T_PAGE;
      2: return T_MASS;
      default: return T_COMMIT;
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int op, input logic [AW-1:0] a);
    if (op == 0) return a & ~18'h3;
    if (op == 1) return a & ~18'h3FF;
    return a;
  endfunction

  function automatic logic [31:0] exp_data(input int op, input logic [31:0] d);
    return (op == 0) ? d : 32'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    reg_rsel = s;
    #1;
    v = reg_rdata;
  endtask

  // Waits (at negedges) for the handshake; checks that the offer holds steady.
  task automatic wait_hs();
    logic [1:0] o0; logic [AW-1:0] a0; logic [31:0] d0;
    o0 = cmd_op; a0 = cmd_addr; d0 = cmd_data;
    while (!(cmd_valid && cmd_ready)) begin
      @(negedge clk);
      if (cmd_op !== o0 || cmd_addr !== a0 || cmd_data !== d0 || !cmd_valid) begin
        chk("R5 offer stable", {cmd_valid, cmd_op, cmd_addr}, {1'b1, o0, a0});
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v); chk("R1 reset register", v, 32'd0);
    end
    chk("R1 reset cmd_valid", 32'(cmd_valid), 0);
    chk("R1 reset irq", 32'(irq), 0);

    // R2 address truncation and data width
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, v); chk("R2 address upper bits", v, 32'h0003_FFFF);
    wr(3'd1, 32'hDEAD_BEEF); rd(3'd1, v); chk("R2 data register", v, 32'hDEAD_BEEF);

    // R4 rejected control writes
    wr(3'd2, {16'hA443, 16'h0001}); rd(3'd2, v); chk("R4 wrong key", v, 0);
    chk("R4 wrong key valid", 32'(cmd_valid), 0);
    wr(3'd2, {16'h0000, 16'h0001}); rd(3'd2, v); chk("R4 no key", v, 0);
    wr(3'd2, {KEY, 16'h0003}); rd(3'd2, v); chk("R4 two bits", v, 0);
    chk("R4 two bits valid", 32'(cmd_valid), 0);
    wr(3'd2, {KEY, 16'h0000}); rd(3'd2, v); chk("R4 zero bits", v, 0);

    // R8 blocked writes while stalled
    ready_mode = 0;
    wr(3'd0, 32'h0001_2345);
    wr(3'd1, 32'h1111_2222);
    wr(3'd2, {KEY, 16'h0001});
    chk("R5 word offer valid", 32'(cmd_valid), 1);
    chk("R6 word address", 32'(cmd_addr), 32'h0001_2344);
    wr(3'd0, 32'h0000_0FFF); rd(3'd0, v); chk("R8 address blocked", v, 32'h0001_2345);
    wr(3'd1, 32'h3333_4444); rd(3'd1, v); chk("R8 data blocked", v, 32'h1111_2222);
    wr(3'd2, {KEY, 16'h0008}); rd(3'd2, v); chk("R8 control blocked", v, 32'h1);
    chk("R8 offer unchanged", {cmd_op, cmd_data[29:0]}, {2'd0, 30'h1111_2222});
    ready_mode = 1;
    wait_hs();
    repeat (T_WORD) @(negedge clk);
    rd(3'd2, v); chk("R7 word busy last cycle", v, 32'h1);
    @(negedge clk);
    rd(3'd2, v); chk("R7 word cleared", v, 0);
    rd(3'd4, v); chk("R9 raw set", v, 1);
    chk("R9 irq masked off", 32'(irq), 0);
    wr(3'd3, 32'h1);
    chk("R9 irq with mask", 32'(irq), 1);
    rd(3'd5, v); chk("R9 masked status", v, 1);
    wr(3'd5, 32'h0); rd(3'd4, v); chk("R9 write zero keeps raw", v, 1);
    wr(3'd5, 32'h1); rd(3'd4, v); chk("R9 clear raw", v, 0);
    chk("R9 irq after clear", 32'(irq), 0);

    // R9 completion and clear on the same edge
    wr(3'd0, 32'h0002_07FF);
    wr(3'd2, {KEY, 16'h0008});
    chk("R6 commit address", 32'(cmd_addr), 32'h0002_07FF);
    chk("R6 commit data", cmd_data, 0);
    wait_hs();
    repeat (T_COMMIT - 1) @(negedge clk);
    wr(3'd5, 32'h1);
    rd(3'd2, v); chk("R7 commit cleared", v, 0);
    rd(3'd4, v); chk("R9 completion beats clear", v, 1);
    wr(3'd5, 32'h1); rd(3'd4, v); chk("R9 clear after collision", v, 0);

    // Random operations with random ready stalls
    for (int n = 0; n < 12; n++) begin
      int op; logic [AW-1:0] a; logic [31:0] d; logic m;
      op = (n == 5) ? 2 : int'($urandom_range(0, 3));
      if (op == 2 && n != 5) op = 1;
      a = AW'($urandom); d = $urandom; m = 1'($urandom_range(0, 1));
      ready_mode = 2;
      wr(3'd3, 32'(m));
      wr(3'd0, 32'(a));
      wr(3'd1, d);
      wr(3'd2, {KEY, 12'd0, 4'(1 << op)});
      rd(3'd2, v); chk("R3 command bit", v, 32'(1 << op));
      chk("R5 op code", 32'(cmd_op), 32'(op));
      chk("R6 address", 32'(cmd_addr), 32'(exp_addr(op, a)));
      chk("R6 data", cmd_data, exp_data(op, d));
      wait_hs();
      ready_mode = 1;
      repeat (dur(op)) @(negedge clk);
      rd(3'd2, v); chk("R7 busy to end", v, 32'(1 << op));
      @(negedge clk);
      rd(3'd2, v); chk("R7 self clear", v, 0);
      chk("R9 irq follows mask", 32'(irq), 32'(m));
      wr(3'd5, 32'h1);
      rd(3'd4, v); chk("R9 raw cleared", v, 0);
    end

    rd(3'd6, v); chk("R9 unused select", v, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule